// File: doc/BRIEF.md
# Stereo Overrange Flag Multiplexer

This block turns short overrange pulses from the left and right channels of a stereo converter into a single active-low flag line. The line carries both channels in turn, following the frame clock of the serial audio port. When a pulse arrives, the status of that channel drops low at once. It stays low until one hold-off timer, shared by both channels, runs out. Either channel can restart that timer. The line is updated on falling bit-clock edges, and its changes trail each frame-clock transition by one bit period in left-justified format and by two in I2S format.

A companion receiver is built into the same top module. It samples the flag line on each frame-clock transition and splits it back into a left and a right status bit, the way a downstream controller would. The bit clock is given as a one-cycle strobe on the system clock, marking each falling bit-clock edge. The frame clock is given as a level that changes only on such a strobe.

Top module: `ovf_flag_mux_top`

## Requirements
- R1: After reset, the flag line and both receiver outputs are high (no overflow), and the hold-off timer is stopped.
- R2: A pulse on `ovr_left` makes the left status low on the next clock. During the left half of the frame, the flag line then reads low from the next bit strobe onward.
- R3: A pulse on `ovr_right` makes the right status low in the same way, and has no effect on the left status.
- R4: Once the timer is running, it counts frame-clock transitions. After 2^(TMO_LOG2+1+k) of them, both statuses return high together and the timer stops. Each frame holds two transitions, so this is 2^(TMO_LOG2+k) frames. k is 0 when `speed` is 00 (single rate), 1 when it is 01 (double rate), and 2 when it is 10 or 11 (quad rate).
- R5: An overrange on either channel clears the transition count, so the timeout for both channels restarts from that pulse.
- R6: With the same TMO_LOG2, the timeout lasts twice as many frames at double rate and four times as many at quad rate as at single rate.
- R7: The flag line changes only on bit strobes. It shows the new half's channel from the first strobe after a frame-clock transition when `fmt_i2s`=0, and from the second strobe when `fmt_i2s`=1.
- R8: When `fmt_i2s`=0, a high frame clock is the left half. When `fmt_i2s`=1, a low frame clock is the left half.
- R9: When `fmt_i2s`=0, the receiver stores the line value into `rx_right_n` on a rising frame-clock transition and into `rx_left_n` on a falling one.
- R10: When `fmt_i2s`=1, the receiver stores the line value into `rx_right_n` on a falling frame-clock transition and into `rx_left_n` on a rising one.
- R11: An overrange in the same cycle as the final counted transition wins. No status is released, and the timer restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each falling bit-clock edge |
| frame_clk | input | 1 | Frame clock level; changes only together with `bit_tick` |
| fmt_i2s | input | 1 | 0 = left-justified, 1 = I2S |
| speed | input | 2 | 00 single, 01 double, 10/11 quad rate |
| ovr_left | input | 1 | Left-channel overrange pulse |
| ovr_right | input | 1 | Right-channel overrange pulse |
| ovfl_n | output | 1 | Time-multiplexed active-low flag line |
| rx_left_n | output | 1 | Receiver's demultiplexed left status |
| rx_right_n | output | 1 | Receiver's demultiplexed right status |

## Verification
The statuses settle one clock after an overrange pulse. The flag line then trails by up to one bit strobe within the matching half, and the receiver outputs move only at the next frame-clock transition. The release comes one clock after the final counted transition. In the bench, a behavioural model keeps a queue of past frame-clock samples and integer counters, and it is stepped on the same rising edge as the design. All three outputs are compared on the falling edge of every clock, so every lag is checked to the exact cycle. The directed checks wait well past the worst-case lag before they read the receiver, and a sweep of pulse offsets lands overrange pulses on the expiry cycle itself.

// File: rtl/ovf_flag_pkg.sv
package ovf_flag_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_SPARE  = 2'b11
    } speed_e;

    // extra power of two applied to the timeout for each rate
    function automatic logic [1:0] rate_shift(input logic [1:0] spd);
        case (speed_e'(spd))
            SPD_SINGLE: rate_shift = 2'd0;
            SPD_DOUBLE: rate_shift = 2'd1;
            default:    rate_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/ovf_hold_timer.sv
module ovf_hold_timer #(
    parameter int TMO_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_l,
    input  logic       ovr_r,
    input  logic       fr_edge,
    input  logic [1:0] speed,
    output logic       stat_l_n,
    output logic       stat_r_n
);
    import ovf_flag_pkg::*;

    localparam int CW    = TMO_LOG2 + 4;
    localparam int SLACK = CW - TMO_LOG2 - 1;

    typedef struct packed {
        logic          stat_l;
        logic          stat_r;
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [CW-1:0] lim_m1;
    logic          any_ovr;

    always_comb begin
        lim_m1  = {CW{1'b1}} >> (SLACK - int'(rate_shift(speed)));
        any_ovr = ovr_l | ovr_r;
        tmr_d   = tmr_q;
        if (any_ovr) begin
            tmr_d.stat_l = tmr_q.stat_l & ~ovr_l;
            tmr_d.stat_r = tmr_q.stat_r & ~ovr_r;
            tmr_d.cnt    = '0;
            tmr_d.run    = 1'b1;
        end else if (fr_edge && tmr_q.run) begin
            if (tmr_q.cnt >= lim_m1) begin
                tmr_d.stat_l = 1'b1;
                tmr_d.stat_r = 1'b1;
                tmr_d.run    = 1'b0;
                tmr_d.cnt    = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{stat_l: 1'b1, stat_r: 1'b1, run: 1'b0, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign stat_l_n = tmr_q.stat_l;
    assign stat_r_n = tmr_q.stat_r;

    AST_LEFT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_l |=> !stat_l_n) else $error("left status not low after overrange"); // R2
    AST_RIGHT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_r |=> !stat_r_n) else $error("right status not low after overrange"); // R3
    AST_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_l_n) |-> ($past(fr_edge) && !$past(ovr_l || ovr_r))) else $error("left released off a frame edge"); // R4
    AST_OVR_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_l || ovr_r) |=> (!$rose(stat_l_n) && !$rose(stat_r_n))) else $error("release in overrange cycle"); // R11

endmodule

// File: rtl/ovf_line_mux.sv
module ovf_line_mux #(
    parameter int LAG_LJ  = 1,
    parameter int LAG_I2S = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_clk,
    input  logic fmt_i2s,
    input  logic stat_l_n,
    input  logic stat_r_n,
    output logic fr_edge,
    output logic ovfl_n
);
    localparam int DEPTH = (LAG_I2S > LAG_LJ) ? LAG_I2S : LAG_LJ;

    typedef struct packed {
        logic [DEPTH-1:0] tap;
        logic             line;
    } mux_t;

    mux_t mux_d, mux_q;
    logic half_sel;
    logic left_half;
    logic [DEPTH:0] tap_ext;

    always_comb begin
        tap_ext   = {mux_q.tap, frame_clk};
        fr_edge   = bit_tick & (frame_clk ^ mux_q.tap[0]);
        half_sel  = fmt_i2s ? mux_q.tap[LAG_I2S-1] : mux_q.tap[LAG_LJ-1];
        left_half = half_sel ^ fmt_i2s;
        mux_d     = mux_q;
        if (bit_tick) begin
            mux_d.line = left_half ? stat_l_n : stat_r_n;
            mux_d.tap  = tap_ext[DEPTH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q <= '{tap: '0, line: 1'b1};
        end else begin
            mux_q <= mux_d;
        end
    end

    assign ovfl_n = mux_q.line;

    AST_LINE_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(ovfl_n)) else $error("flag line moved between strobes"); // R7
    AST_LINE_HIGH_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && stat_l_n && stat_r_n) |=> ovfl_n) else $error("flag low with both statuses clear"); // R8

endmodule

// File: rtl/ovf_flag_demux.sv
module ovf_flag_demux (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_clk,
    input  logic fmt_i2s,
    input  logic line_n,
    output logic rx_left_n,
    output logic rx_right_n
);
    typedef struct packed {
        logic fprev;
        logic rx_l;
        logic rx_r;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic edge_seen;

    always_comb begin
        edge_seen = bit_tick & (frame_clk ^ rx_q.fprev);
        rx_d      = rx_q;
        if (bit_tick) begin
            rx_d.fprev = frame_clk;
        end
        if (edge_seen) begin
            if (frame_clk ^ fmt_i2s) begin
                rx_d.rx_r = line_n;
            end else begin
                rx_d.rx_l = line_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '{fprev: 1'b0, rx_l: 1'b1, rx_r: 1'b1};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_left_n  = rx_q.rx_l;
    assign rx_right_n = rx_q.rx_r;

    AST_RX_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(rx_left_n) && $stable(rx_right_n))) else $error("receiver moved between strobes"); // R9
    AST_RX_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> ($stable(rx_left_n) || $stable(rx_right_n))) else $error("receiver wrote both sides"); // R10

endmodule

// File: rtl/ovf_flag_mux_top.sv
module ovf_flag_mux_top #(
    parameter int TMO_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       frame_clk,
    input  logic       fmt_i2s,
    input  logic [1:0] speed,
    input  logic       ovr_left,
    input  logic       ovr_right,
    output logic       ovfl_n,
    output logic       rx_left_n,
    output logic       rx_right_n
);
    logic stat_l_n;
    logic stat_r_n;
    logic fr_edge;

    ovf_hold_timer #(.TMO_LOG2(TMO_LOG2)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_l    (ovr_left),
        .ovr_r    (ovr_right),
        .fr_edge  (fr_edge),
        .speed    (speed),
        .stat_l_n (stat_l_n),
        .stat_r_n (stat_r_n)
    );

    ovf_line_mux #(.LAG_LJ(1), .LAG_I2S(2)) mux_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .frame_clk (frame_clk),
        .fmt_i2s   (fmt_i2s),
        .stat_l_n  (stat_l_n),
        .stat_r_n  (stat_r_n),
        .fr_edge   (fr_edge),
        .ovfl_n    (ovfl_n)
    );

    ovf_flag_demux rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_clk  (frame_clk),
        .fmt_i2s    (fmt_i2s),
        .line_n     (ovfl_n),
        .rx_left_n  (rx_left_n),
        .rx_right_n (rx_right_n)
    );

endmodule

// File: tb/ovf_flag_mux_top_tb.sv
module ovf_flag_mux_top_tb_top;
    localparam int TMO = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       frame_clk = 1'b0;
    logic       fmt_i2s = 1'b0;
    logic [1:0] speed = 2'b00;
    logic       ovr_left = 1'b0;
    logic       ovr_right = 1'b0;
    logic       ovfl_n, rx_left_n, rx_right_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    ovf_flag_mux_top #(.TMO_LOG2(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_clk(frame_clk),
        .fmt_i2s(fmt_i2s), .speed(speed), .ovr_left(ovr_left), .ovr_right(ovr_right),
        .ovfl_n(ovfl_n), .rx_left_n(rx_left_n), .rx_right_n(rx_right_n)
    );

    // bit strobe every 4 clocks, 8 strobes per frame half
    int ph = 0;
    int bc = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0; bc = 0; bit_tick = 1'b0; frame_clk = 1'b0;
        end else begin
            bit_tick = (ph == 0);
            if (ph == 0) begin
                bc++;
                if (bc == 8) begin
                    bc = 0;
                    frame_clk = ~frame_clk;
                end
            end
            ph = (ph + 1) % 4;
        end
    end

    // behavioural reference
    bit m_l, m_r, m_run, m_out, m_rxl, m_rxr;
    int m_cnt;
    bit hist[$];
    always @(posedge clk) begin
        bit ol, or_, oo, edg, half;
        int sh, lim;
        if (!rst_n) begin
            m_l = 1; m_r = 1; m_run = 0; m_cnt = 0; m_out = 1; m_rxl = 1; m_rxr = 1;
            hist = '{1'b0, 1'b0};
        end else begin
            ol = m_l; or_ = m_r; oo = m_out;
            sh = (speed == 2'b00) ? 0 : (speed == 2'b01) ? 1 : 2;
            lim = 1 << (TMO + 1 + sh);
            edg = bit_tick && (frame_clk != hist[0]);
            if (ovr_left || ovr_right) begin
                if (ovr_left)  m_l = 0;
                if (ovr_right) m_r = 0;
                m_cnt = 0; m_run = 1;
            end else if (edg && m_run) begin
                m_cnt++;
                if (m_cnt >= lim) begin
                    m_run = 0; m_l = 1; m_r = 1; m_cnt = 0;
                end
            end
            if (edg) begin
                if (frame_clk ^ fmt_i2s) m_rxr = oo;
                else                     m_rxl = oo;
            end
            if (bit_tick) begin
                half = fmt_i2s ? hist[1] : hist[0];
                m_out = (half ^ fmt_i2s) ? ol : or_;
                hist.push_front(frame_clk);
                void'(hist.pop_back());
            end
        end
    end

    string phase_req = "R1";
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (ovfl_n !== m_out) begin
                errors++;
                $display("FAIL R7 R8 (%s) ovfl_n act=%b exp=%b t=%0t", phase_req, ovfl_n, m_out, $time);
            end
            if (rx_left_n !== m_rxl || rx_right_n !== m_rxr) begin
                errors++;
                $display("FAIL R9 R10 (%s) rx act=%b%b exp=%b%b t=%0t", phase_req,
                         rx_left_n, rx_right_n, m_rxl, m_rxr, $time);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(input logic l, input logic r);
        @(negedge clk); #1; ovr_left = l; ovr_right = r;
        @(negedge clk); #1; ovr_left = 1'b0; ovr_right = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        @(negedge clk); #1; rst_n = 1'b1;
        wait_clk(3);
        chk("R1 reset line", ovfl_n, 1'b1);
        chk("R1 reset rx left", rx_left_n, 1'b1);
        chk("R1 reset rx right", rx_right_n, 1'b1);

        phase_req = "R2";
        pulse(1'b1, 1'b0);
        wait_clk(100);
        chk("R2 left latched low", rx_left_n, 1'b0);
        chk("R3 right unaffected", rx_right_n, 1'b1);
        phase_req = "R4";
        wait_clk(400);
        chk("R4 left released", rx_left_n, 1'b1);

        phase_req = "R5";
        pulse(1'b0, 1'b1);
        wait_clk(150);
        pulse(1'b1, 1'b0);
        wait_clk(200);
        chk("R5 right held by restart", rx_right_n, 1'b0);
        chk("R5 left low", rx_left_n, 1'b0);
        wait_clk(400);
        chk("R5 right released", rx_right_n, 1'b1);
        chk("R5 left released", rx_left_n, 1'b1);

        phase_req = "R10";
        @(negedge clk); #1; fmt_i2s = 1'b1;
        pulse(1'b0, 1'b1);
        wait_clk(100);
        chk("R10 i2s right low", rx_right_n, 1'b0);
        chk("R8 i2s left high", rx_left_n, 1'b1);
        wait_clk(400);
        chk("R4 i2s right released", rx_right_n, 1'b1);

        phase_req = "R6";
        @(negedge clk); #1; speed = 2'b01;
        pulse(1'b1, 1'b0);
        wait_clk(400);
        chk("R6 double still low", rx_left_n, 1'b0);
        wait_clk(350);
        chk("R6 double released", rx_left_n, 1'b1);
        @(negedge clk); #1; speed = 2'b10; fmt_i2s = 1'b0;
        pulse(1'b1, 1'b1);
        wait_clk(800);
        chk("R6 quad still low", rx_left_n, 1'b0);
        wait_clk(500);
        chk("R6 quad released", rx_right_n, 1'b1);

        phase_req = "R11";
        @(negedge clk); #1; speed = 2'b00;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1; fmt_i2s = k[0];
            pulse(1'b0, 1'b1);
            wait_clk(210 + k);
            pulse(1'b1, 1'b0);
            wait_clk(600);
            chk("R11 sweep both released", rx_left_n & rx_right_n, 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule